// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel data ports, A and B, of a configurable width. Each port owns a holding register that loads the word present on that port whenever its own capture strobe rises. One active-low enable and one direction input decide which port the block drives: A, B or neither. For each direction, a select input picks what the driven port shows. It is either the live word on the opposite port, passed straight through in the same cycle, or the word last captured from that port.

Each bidirectional bus is split into an input vector, an output vector and an output-enable bit, so the block stays synthesizable. The two capture strobes are ordinary data inputs sampled in one system clock domain. A rising strobe is found by edge detection and loads the register at the next system clock edge. Capture does not depend on the enable or direction settings. Words can therefore be parked in either register while both ports are isolated, and sent out later.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, both holding registers are cleared to zero. After reset, a stored-mode transfer in either direction outputs zero until a capture occurs.
- R2: When `a_cap` is sampled high and was sampled low at the previous clock edge, the A register loads `a_in` at that edge.
- R3: When `b_cap` is sampled high and was sampled low at the previous clock edge, the B register loads `b_in` at that edge.
- R4: Capture into both registers happens under every setting of `oe_n`, `dir` and the selects, including isolation.
- R5: With `oe_n` high, `a_oe` and `b_oe` are both 0 and `a_out` and `b_out` are both zero.
- R6: With `oe_n` low, `dir` = 1 sets `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 sets `a_oe` = 1 and `b_oe` = 0. The output of the port that is not driven is zero.
- R7: `a_oe` and `b_oe` are never 1 at the same time.
- R8: While B is driven and `sel_a2b` = 0, `b_out` equals `a_in` in the same cycle. While A is driven and `sel_b2a` = 0, `a_out` equals `b_in` in the same cycle.
- R9: While B is driven and `sel_a2b` = 1, `b_out` equals the A register.
- R10: While A is driven and `sel_b2a` = 1, `a_out` equals the B register.
- R11: In stored mode, a capture on the source side changes the driven output to the newly captured word from the clock edge that performs the capture onward. It does not change it earlier.
- R12: The select of the direction that is not being driven has no effect on either output.
- R13: A capture strobe that stays high, or stays low, does not load its register, whatever the data input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cap | input | 1 | A-side capture strobe, acts on its rising edge |
| b_cap | input | 1 | B-side capture strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low output enable shared by both ports |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_a2b | input | 1 | 0: B shows live A; 1: B shows the A register |
| sel_b2a | input | 1 | 0: A shows live B; 1: A shows the B register |
| a_in | input | W | Word received on port A |
| b_in | input | W | Word received on port B |
| a_out | output | W | Word driven onto port A |
| a_oe | output | 1 | Port A driver enable |
| b_out | output | W | Word driven onto port B |
| b_oe | output | 1 | Port B driver enable |

## Verification
On every cycle the assertions check that at most one port is driven, that each enable follows `oe_n` and `dir`, and that the driven output matches either the live opposite input or the opposite register, as its select demands. They also check that a register loads only on a detected strobe rise and keeps its value at all other times. The bench scenarios show what needs a history of stimulus. These are: the cleared state after reset, words parked during isolation and sent out later, the exact cycle in which a stored-mode output takes a new word, and the select of the idle direction having no effect.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered bus transceiver.
package xcvr_pkg;
    // Which port, if any, the block currently drives.
    typedef enum logic [1:0] {
        PATH_ISOLATE = 2'd0,
        PATH_TO_B    = 2'd1,
        PATH_TO_A    = 2'd2
    } path_e;

    // Side indices for the generated capture registers.
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/xcvr_capture.sv
// Holding register for one port. It detects a rising edge of the capture
// strobe, sampled in the system clock domain, and loads the port word on
// that edge. Assumes the strobe is synchronous to clk and stays high or low
// for at least one clock.
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic         strobe_q;
    logic [W-1:0] hold_r;
    logic         rise;

    // Rising edge = strobe high now, low at the previous sample.
    assign rise = strobe_i && !strobe_q;

    // Track the previous strobe level (also during reset, so no false edge appears).
    always_ff @(posedge clk) begin
        strobe_q <= strobe_i;
    end

    // Clear on reset, otherwise load the port word on a detected rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_r <= '0;
        end else if (rise) begin
            hold_r <= d_i;
        end
    end

    assign q_o = hold_r;

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_i) |=> (q_o == $past(d_i)));                       // R2
    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(strobe_i) |=> $stable(q_o));                             // R13
endmodule

// File: rtl/xcvr_route.sv
// Output routing. It decodes the enable and direction inputs into a path,
// then selects live or stored data for the driven port. Undriven ports output
// zero. Purely combinational; clk and rst_n feed only the assertions.
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_a2b,
    input  logic         sel_b2a,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] a_held,
    input  logic [W-1:0] b_held,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    path_e        path;
    logic [W-1:0] word_to_b;
    logic [W-1:0] word_to_a;

    // Decode enable and direction into one path.
    always_comb begin
        if (oe_n)     path = PATH_ISOLATE;
        else if (dir) path = PATH_TO_B;
        else          path = PATH_TO_A;
    end

    // Choose a live or stored word for each direction.
    always_comb begin
        word_to_b = sel_a2b ? a_held : a_in;
        word_to_a = sel_b2a ? b_held : b_in;
    end

    // Drive only the port the path selects.
    always_comb begin
        a_oe  = 1'b0;
        b_oe  = 1'b0;
        a_out = '0;
        b_out = '0;
        unique case (path)
            PATH_TO_B: begin
                b_oe  = 1'b1;
                b_out = word_to_b;
            end
            PATH_TO_A: begin
                a_oe  = 1'b1;
                a_out = word_to_a;
            end
            default: ;
        endcase
    end

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));                                               // R7
    AST_ISOLATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));       // R5
    AST_DIR_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir) |-> (b_oe && !a_oe && a_out == '0));             // R6
    AST_DIR_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir) |-> (a_oe && !b_oe && b_out == '0));            // R6
    AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_oe && !sel_a2b) |-> b_out == a_in) and
        ((a_oe && !sel_b2a) |-> a_out == b_in));                        // R8
    AST_STORED_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && sel_a2b) |-> (b_out == a_held));                       // R9
    AST_STORED_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && sel_b2a) |-> (a_out == b_held));                       // R10
endmodule

// File: rtl/bus_xcvr_reg.sv
// Registered bidirectional bus transceiver top. There is one capture register
// per port, generated from the side index, followed by the shared router.
// Assumes both capture strobes are synchronous to clk.
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_cap,
    input  logic         b_cap,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_a2b,
    input  logic         sel_b2a,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic         side_strobe [NUM_SIDES];
    logic [W-1:0] side_word   [NUM_SIDES];
    logic [W-1:0] side_held   [NUM_SIDES];

    // Gather per-side inputs so the capture registers can be generated.
    always_comb begin
        side_strobe[SIDE_A] = a_cap;
        side_strobe[SIDE_B] = b_cap;
        side_word[SIDE_A]   = a_in;
        side_word[SIDE_B]   = b_in;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        xcvr_capture #(.W(W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (side_strobe[s]),
            .d_i      (side_word[s]),
            .q_o      (side_held[s])
        );
    end

    xcvr_route #(.W(W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (oe_n),
        .dir     (dir),
        .sel_a2b (sel_a2b),
        .sel_b2a (sel_b2a),
        .a_in    (a_in),
        .b_in    (b_in),
        .a_held  (side_held[SIDE_A]),
        .b_held  (side_held[SIDE_B]),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_out   (b_out),
        .b_oe    (b_oe)
    );
endmodule

// File: tb/tb_bus_xcvr_reg.sv
// Directed bench. Inputs change on the falling clock edge and outputs are
// checked 1 ns later. A reference model tracks both registers.
module tb_bus_xcvr_reg;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         a_cap, b_cap, oe_n, dir, sel_a2b, sel_b2a;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int n_checks = 0;
    int n_fails  = 0;
    logic [W-1:0] ref_a, ref_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_xcvr_reg #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .a_cap(a_cap), .b_cap(b_cap),
        .oe_n(oe_n), .dir(dir), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output against the model built from the requirements.
    task automatic check_all(input string tag);
        logic [W-1:0] ea, eb;
        logic eoa, eob;
        eoa = !oe_n && !dir;
        eob = !oe_n && dir;
        ea  = eoa ? (sel_b2a ? ref_b : b_in) : '0;
        eb  = eob ? (sel_a2b ? ref_a : a_in) : '0;
        check({tag, " a_oe"},  W'(a_oe), W'(eoa));
        check({tag, " b_oe"},  W'(b_oe), W'(eob));
        check({tag, " a_out"}, a_out, ea);
        check({tag, " b_out"}, b_out, eb);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // Give one strobe pulse on A, B or both; the capture lands at the next rising edge.
    task automatic pulse(input logic do_a, input logic do_b,
                         input logic [W-1:0] wa, input logic [W-1:0] wb);
        @(negedge clk);
        a_in = wa; b_in = wb;
        a_cap = do_a; b_cap = do_b;
        @(negedge clk);
        a_cap = 1'b0; b_cap = 1'b0;
        if (do_a) ref_a = wa;
        if (do_b) ref_b = wb;
        #1;
    endtask

    task automatic set_ctl(input logic oen, input logic d, input logic sab, input logic sba);
        @(negedge clk);
        oe_n = oen; dir = d; sel_a2b = sab; sel_b2a = sba;
        #1;
    endtask

    task automatic t_reset();
        // A strobe during reset must not survive; registers clear (R1).
        @(negedge clk); a_cap = 1'b1; a_in = 8'hFF;
        @(negedge clk); a_cap = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ref_a = '0; ref_b = '0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R1 stored A after reset", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R1 stored B after reset", a_out, 8'h00);
        check_all("R1");
    endtask

    task automatic t_live_a2b();
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a_in = W'(8'h11 * (i + 3)); b_in = W'(8'hA5 ^ i);
            #1;
            check("R8 live A to B", b_out, a_in);
            check_all("R6 R8 a2b");
        end
    endtask

    task automatic t_live_b2a();
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            b_in = W'(8'h0F << i); a_in = W'(i);
            #1;
            check("R8 live B to A", a_out, b_in);
            check_all("R6 R8 b2a");
        end
    endtask

    task automatic t_isolate_capture();
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
        pulse(1'b1, 1'b1, 8'h3C, 8'hC3);
        check_all("R5 R4 isolated");
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R4 R9 A word parked in isolation", b_out, 8'h3C);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R4 R10 B word parked in isolation", a_out, 8'hC3);
    endtask

    task automatic t_stored_update();
        // Drive B from the A register, then capture a new A word.
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        a_in = 8'h5A; a_cap = 1'b1;
        #1;
        check("R11 no early update", b_out, 8'h3C);
        @(posedge clk); #1;
        check("R11 R2 update at capture edge", b_out, 8'h5A);
        @(negedge clk); a_cap = 1'b0; ref_a = 8'h5A;
        a_in = 8'h77; #1;
        check("R9 stored ignores live A", b_out, 8'h5A);
        // Same on the A side from the B register (R3).
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b1, 8'h00, 8'hE1);
        check("R3 R10 B capture to A", a_out, 8'hE1);
        check_all("R10");
    endtask

    task automatic t_hold_level();
        // The strobe stays high while the data changes: no load (R13).
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        pulse(1'b1, 1'b0, 8'h42, 8'h00);
        @(negedge clk); a_cap = 1'b1; a_in = 8'h99;
        @(negedge clk); ref_a = 8'h99;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); a_in = W'(8'h20 + i); #1;
            check("R13 held-high strobe no reload", b_out, 8'h99);
        end
        @(negedge clk); a_cap = 1'b0; a_in = 8'hEE;
        settle();
        check("R13 low strobe no load", b_out, 8'h99);
    endtask

    task automatic t_idle_select();
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk); a_in = 8'h6B; b_in = 8'h14; #1;
        check("R12 ref", b_out, 8'h6B);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
        check("R12 sel_b2a idle B", b_out, 8'h6B);
        check("R12 sel_b2a idle A", a_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
        check("R12 sel_a2b idle A", a_out, 8'h14);
        check("R12 sel_a2b idle B", b_out, 8'h00);
        check_all("R7 R12");
    endtask

    initial begin
        rst_n = 1'b0; a_cap = 1'b0; b_cap = 1'b0; oe_n = 1'b1; dir = 1'b0;
        sel_a2b = 1'b0; sel_b2a = 1'b0; a_in = '0; b_in = '0;
        ref_a = '0; ref_b = '0;
        repeat (2) @(negedge clk);
        t_reset();
        t_live_a2b();
        t_live_b2a();
        t_isolate_capture();
        t_stored_update();
        t_hold_level();
        t_idle_select();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule